// File: doc/BRIEF.md
# Display Serial Link Packet Stream Analyzer

This block watches one lane of a display serial link after the physical layer has deserialized and aligned its bytes. It cuts the stream into packets and decodes each four-byte header. Short packets are told apart from long packets, and long payloads are skipped using their word count. Every header produces one record on the output. The record gives the virtual channel, the 6-bit type code and the 16-bit parameter or word count. It also flags a header check error and marks the first packet of a burst. Each record carries the byte offset within the burst, so the position of each sync packet in time is known.

A burst-boundary input marks the moment the link drops back to its low-power stop state. When it is seen, the block reports a summary of the burst. The summary gives the number of bytes and a flag that is set when the burst closed without an end-of-transmission packet. The parser is then made ready for a fresh header.

A per-line tally counts null fill, blanking fill, 24-bit pixel lines, sync packets and all other packets. The tally is published each time a horizontal sync start packet is seen. This shows which fill style a source uses in its porches. The block only observes the stream. It never changes or corrects it.

Top module: `dsi_stream_analyzer`

## Requirements
- R1: While reset is held and in the first cycle after it, rec_valid, burst_done and line_valid are low, and the first line report after reset counts only packets received since reset.
- R2: A short packet is the four bytes {ID, P1, P2, ECC}. One cycle after the clock edge that takes the fourth byte, rec_valid pulses for one cycle. At that point rec_vc = ID[7:6], rec_dt = ID[5:0], rec_param = {P2, P1} and rec_long = 0.
- R3: A type code whose low four bits are 9 or greater (for example 0x09, 0x19, 0x2B, 0x3E) is long. Its header is followed by word-count payload bytes, then two checksum bytes, and the next header starts right after them. The record has rec_long = 1 and rec_param = the little-endian word count {P2, P1}. A word count of 0 still skips the two checksum bytes.
- R4: rec_ecc_err is 1 when ECC[5:0] differs from the standard 6-bit Hamming code of the 24 header bits, or when ECC[7:6] is nonzero. For example, header 09 00 00 has code 09. The packet is still sized and skipped as if the header were correct.
- R5: burst_end high resets the parser to expect a new header, and any byte offered in that same cycle is ignored. A packet cut short by burst_end produces no further record. The first header of the next burst is decoded correctly.
- R6: rec_first is 1 only on the first record of a burst. rec_offset is the number of bytes taken in the burst before the header's first byte, so the first record of a burst has offset 0.
- R7: One cycle after a burst_end cycle that closes a burst which took at least one byte, burst_done pulses. burst_bytes then holds the byte count of that burst. burst_no_eot is 1 unless the burst's last record had type code 0x08, and that last record may be produced in the burst_end cycle itself. A burst_end with no bytes since the previous one gives no pulse.
- R8: The cycle after a record with type code 0x21 (horizontal sync start), line_valid pulses. The five counts then cover all records since the previous 0x21 record, not including the new one. The new 0x21 record opens the next line with a sync count of 1.
- R9: Categories use type code bits 5:0 only, whatever the virtual channel. null = 0x09 and blank = 0x19 are counted apart. pixel = 0x3E. sync = 0x01, 0x11, 0x21, 0x31. Every other code counts as other.
- R10: Each line count saturates at its all-ones value (255 with the default CNT_W = 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | byte_data carries a lane byte this cycle |
| byte_data | input | 8 | Aligned lane byte |
| burst_end | input | 1 | Link returned to the stop state; closes the burst |
| rec_valid | output | 1 | One-cycle pulse: packet record valid |
| rec_vc | output | 2 | Virtual channel of the packet |
| rec_dt | output | 6 | Type code of the packet |
| rec_param | output | 16 | Word count (long) or {P2,P1} (short) |
| rec_long | output | 1 | Packet is long |
| rec_ecc_err | output | 1 | Header check mismatch |
| rec_first | output | 1 | First record of the burst |
| rec_offset | output | OFS_W | Byte offset of the header in the burst |
| burst_done | output | 1 | One-cycle pulse: burst summary valid |
| burst_bytes | output | OFS_W | Bytes taken in the closed burst |
| burst_no_eot | output | 1 | Burst ended without an end-of-transmission packet |
| line_valid | output | 1 | One-cycle pulse: line counts valid |
| line_null | output | CNT_W | Null fill packets in the line |
| line_blank | output | CNT_W | Blanking fill packets in the line |
| line_pixel | output | CNT_W | 24-bit pixel packets in the line |
| line_sync | output | CNT_W | Sync packets in the line |
| line_other | output | CNT_W | All other packets in the line |

## Verification
The bench drives a zero-length null packet, a full 376-pixel line and an unknown long type, and checks the offset of every following header. A parser that mishandled the word count, or forgot the two checksum bytes after a zero-length payload, would shift every later header and report wrong types. An end-of-transmission packet whose record coincides with burst_end tests that the burst summary sees it. A design that missed this would falsely flag the burst as lacking the packet. Bursts cut in the payload and in the header test that the next burst starts clean rather than treating its first byte as payload. The line tally is checked for null versus blanking separation under nonzero virtual channels and for saturation past 255.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  localparam logic [5:0] DT_VSS   = 6'h01;
  localparam logic [5:0] DT_VSE   = 6'h11;
  localparam logic [5:0] DT_HSS   = 6'h21;
  localparam logic [5:0] DT_HSE   = 6'h31;
  localparam logic [5:0] DT_EOT   = 6'h08;
  localparam logic [5:0] DT_NULL  = 6'h09;
  localparam logic [5:0] DT_BLANK = 6'h19;
  localparam logic [5:0] DT_RGB24 = 6'h3E;

  typedef enum logic [2:0] {
    CAT_NULL  = 3'd0,
    CAT_BLANK = 3'd1,
    CAT_PIXEL = 3'd2,
    CAT_SYNC  = 3'd3,
    CAT_OTHER = 3'd4
  } cat_e;
  localparam int NUM_CAT = 5;

  // parity row masks of the 6-bit header code, bit i of the code covers these header bits
  localparam logic [23:0] ECC_ROW [6] = '{24'hF12CB7, 24'hF2555B, 24'h749A6D,
                                          24'hB8E38E, 24'hDF03F0, 24'hEFFC00};

  function automatic logic [5:0] header_ecc(input logic [23:0] hdr);
    logic [5:0] e;
    for (int i = 0; i < 6; i++) e[i] = ^(hdr & ECC_ROW[i]);
    return e;
  endfunction

  function automatic logic is_long_type(input logic [5:0] dt);
    return dt[3:0] >= 4'h9;
  endfunction

  function automatic cat_e classify(input logic [5:0] dt);
    case (dt)
      DT_NULL:                        return CAT_NULL;
      DT_BLANK:                       return CAT_BLANK;
      DT_RGB24:                       return CAT_PIXEL;
      DT_VSS, DT_VSE, DT_HSS, DT_HSE: return CAT_SYNC;
      default:                        return CAT_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/dsa_parser.sv
module dsa_parser
  import dsa_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             burst_end,
  input  logic [OFS_W-1:0] burst_pos,
  output logic             hdr_done,
  output logic             rec_valid,
  output logic [1:0]       rec_vc,
  output logic [5:0]       rec_dt,
  output logic [15:0]      rec_param,
  output logic             rec_long,
  output logic             rec_ecc_err,
  output logic             rec_first,
  output logic [OFS_W-1:0] rec_offset
);
  typedef enum logic [1:0] {ST_HDR, ST_BODY, ST_CRC} pst_e;

  pst_e             st;
  logic [1:0]       idx;
  logic [7:0]       b0, b1, b2;
  logic [15:0]      remain;
  logic [OFS_W-1:0] start_pos;
  logic             first_pend;
  logic             take;
  logic             ecc_bad;
  logic             hdr_long;

  assign take     = byte_valid && !burst_end;
  assign hdr_done = take && (st == ST_HDR) && (idx == 2'd3);
  assign ecc_bad  = (byte_data[5:0] != header_ecc({b2, b1, b0})) || (byte_data[7:6] != 2'b00);
  assign hdr_long = is_long_type(b0[5:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_HDR;
      idx         <= 2'd0;
      b0          <= '0;
      b1          <= '0;
      b2          <= '0;
      remain      <= '0;
      start_pos   <= '0;
      first_pend  <= 1'b1;
      rec_valid   <= 1'b0;
      rec_vc      <= '0;
      rec_dt      <= '0;
      rec_param   <= '0;
      rec_long    <= 1'b0;
      rec_ecc_err <= 1'b0;
      rec_first   <= 1'b0;
      rec_offset  <= '0;
    end else begin
      rec_valid <= hdr_done;
      if (burst_end) begin
        st         <= ST_HDR;
        idx        <= 2'd0;
        first_pend <= 1'b1;
      end else if (take) begin
        case (st)
          ST_HDR: begin
            case (idx)
              2'd0: begin b0 <= byte_data; start_pos <= burst_pos; end
              2'd1: b1 <= byte_data;
              2'd2: b2 <= byte_data;
              default: begin
                rec_vc      <= b0[7:6];
                rec_dt      <= b0[5:0];
                rec_param   <= {b2, b1};
                rec_long    <= hdr_long;
                rec_ecc_err <= ecc_bad;
                rec_first   <= first_pend;
                rec_offset  <= start_pos;
                first_pend  <= 1'b0;
                if (hdr_long) begin
                  if ({b2, b1} == 16'd0) begin
                    st     <= ST_CRC;
                    remain <= 16'd1;
                  end else begin
                    st     <= ST_BODY;
                    remain <= {b2, b1} - 16'd1;
                  end
                end
              end
            endcase
            idx <= idx + 2'd1;
          end
          ST_BODY: begin
            if (remain == 16'd0) begin
              st     <= ST_CRC;
              remain <= 16'd1;
            end else begin
              remain <= remain - 16'd1;
            end
          end
          default: begin
            if (remain == 16'd0) st <= ST_HDR;
            else remain <= remain - 16'd1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dsa_burst_tracker.sv
module dsa_burst_tracker
  import dsa_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic             burst_end,
  input  logic             rec_valid,
  input  logic [5:0]       rec_dt,
  output logic [OFS_W-1:0] burst_pos,
  output logic             burst_done,
  output logic [OFS_W-1:0] burst_bytes,
  output logic             burst_no_eot
);
  logic             active;
  logic [OFS_W-1:0] cnt;
  logic             last_eot;
  logic             eot_now;

  assign burst_pos = cnt;
  assign eot_now   = rec_valid ? (rec_dt == DT_EOT) : last_eot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active       <= 1'b0;
      cnt          <= '0;
      last_eot     <= 1'b0;
      burst_done   <= 1'b0;
      burst_bytes  <= '0;
      burst_no_eot <= 1'b0;
    end else begin
      burst_done <= 1'b0;
      if (burst_end) begin
        burst_done <= active;
        if (active) begin
          burst_bytes  <= cnt;
          burst_no_eot <= !eot_now;
        end
        active   <= 1'b0;
        cnt      <= '0;
        last_eot <= 1'b0;
      end else begin
        if (byte_valid) begin
          active <= 1'b1;
          if (cnt != '1) cnt <= cnt + 1'b1;
        end
        if (rec_valid) last_eot <= (rec_dt == DT_EOT);
      end
    end
  end
endmodule

// File: rtl/dsa_line_counter.sv
module dsa_line_counter
  import dsa_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_valid,
  input  logic [5:0]       rec_dt,
  output logic             line_valid,
  output logic [CNT_W-1:0] line_cnt [NUM_CAT]
);
  cat_e       cat;
  logic       is_hss;
  logic [CNT_W-1:0] run [NUM_CAT];

  assign cat    = classify(rec_dt);
  assign is_hss = rec_valid && (rec_dt == DT_HSS);

  always_ff @(posedge clk) begin
    if (!rst_n) line_valid <= 1'b0;
    else        line_valid <= is_hss;
  end

  for (genvar g = 0; g < NUM_CAT; g++) begin : g_cat
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run[g]      <= '0;
        line_cnt[g] <= '0;
      end else if (is_hss) begin
        line_cnt[g] <= run[g];
        run[g]      <= (g == int'(CAT_SYNC)) ? CNT_W'(1) : '0;
      end else if (rec_valid && (cat == cat_e'(g)) && (run[g] != '1)) begin
        run[g] <= run[g] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsi_stream_analyzer.sv
module dsi_stream_analyzer
  import dsa_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             burst_end,
  output logic             rec_valid,
  output logic [1:0]       rec_vc,
  output logic [5:0]       rec_dt,
  output logic [15:0]      rec_param,
  output logic             rec_long,
  output logic             rec_ecc_err,
  output logic             rec_first,
  output logic [OFS_W-1:0] rec_offset,
  output logic             burst_done,
  output logic [OFS_W-1:0] burst_bytes,
  output logic             burst_no_eot,
  output logic             line_valid,
  output logic [CNT_W-1:0] line_null,
  output logic [CNT_W-1:0] line_blank,
  output logic [CNT_W-1:0] line_pixel,
  output logic [CNT_W-1:0] line_sync,
  output logic [CNT_W-1:0] line_other
);
  logic [OFS_W-1:0] burst_pos;
  logic             hdr_done;
  logic [CNT_W-1:0] line_cnt [NUM_CAT];

  dsa_burst_tracker #(.OFS_W(OFS_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .burst_end(burst_end),
    .rec_valid(rec_valid), .rec_dt(rec_dt), .burst_pos(burst_pos),
    .burst_done(burst_done), .burst_bytes(burst_bytes), .burst_no_eot(burst_no_eot)
  );

  dsa_parser #(.OFS_W(OFS_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .burst_end(burst_end), .burst_pos(burst_pos), .hdr_done(hdr_done),
    .rec_valid(rec_valid), .rec_vc(rec_vc), .rec_dt(rec_dt), .rec_param(rec_param),
    .rec_long(rec_long), .rec_ecc_err(rec_ecc_err), .rec_first(rec_first),
    .rec_offset(rec_offset)
  );

  dsa_line_counter #(.CNT_W(CNT_W)) u_line (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_dt(rec_dt),
    .line_valid(line_valid), .line_cnt(line_cnt)
  );

  assign line_null  = line_cnt[CAT_NULL];
  assign line_blank = line_cnt[CAT_BLANK];
  assign line_pixel = line_cnt[CAT_PIXEL];
  assign line_sync  = line_cnt[CAT_SYNC];
  assign line_other = line_cnt[CAT_OTHER];
endmodule

// File: rtl/dsa_checker.sv
module dsa_checker
  import dsa_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_end,
  input logic             hdr_done,
  input logic             rec_valid,
  input logic [5:0]       rec_dt,
  input logic             rec_first,
  input logic [OFS_W-1:0] rec_offset,
  input logic             burst_done,
  input logic             line_valid
);
  p_rec_from_header_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(hdr_done));

  p_rec_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);

  p_flush_on_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !rec_valid);

  p_first_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_first) |-> (rec_offset == '0));

  p_done_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $past(burst_end));

  p_line_after_hss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_dt == DT_HSS) |=> line_valid);

  p_line_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> $past(rec_valid && rec_dt == DT_HSS));
endmodule

bind dsi_stream_analyzer dsa_checker #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_end(burst_end), .hdr_done(hdr_done),
  .rec_valid(rec_valid), .rec_dt(rec_dt), .rec_first(rec_first),
  .rec_offset(rec_offset), .burst_done(burst_done), .line_valid(line_valid)
);

// File: tb/dsi_stream_analyzer_test.sv
module dsi_stream_analyzer_test;
  localparam int PERIOD = 10;
  localparam int OFS_W  = 16;
  localparam int CNT_W  = 8;
  localparam int LOGN   = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic burst_end = 1'b0;
  logic rec_valid, rec_long, rec_ecc_err, rec_first;
  logic [1:0] rec_vc;
  logic [5:0] rec_dt;
  logic [15:0] rec_param;
  logic [OFS_W-1:0] rec_offset, burst_bytes;
  logic burst_done, burst_no_eot, line_valid;
  logic [CNT_W-1:0] line_null, line_blank, line_pixel, line_sync, line_other;

  dsi_stream_analyzer #(.OFS_W(OFS_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .burst_end(burst_end), .rec_valid(rec_valid), .rec_vc(rec_vc), .rec_dt(rec_dt),
    .rec_param(rec_param), .rec_long(rec_long), .rec_ecc_err(rec_ecc_err),
    .rec_first(rec_first), .rec_offset(rec_offset), .burst_done(burst_done),
    .burst_bytes(burst_bytes), .burst_no_eot(burst_no_eot), .line_valid(line_valid),
    .line_null(line_null), .line_blank(line_blank), .line_pixel(line_pixel),
    .line_sync(line_sync), .line_other(line_other)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_cyc = 0;
  bit finished = 0;

  // logs filled by the monitor
  int rn = 0;
  logic [5:0]  r_dt [LOGN];
  logic [1:0]  r_vc [LOGN];
  logic [15:0] r_par [LOGN];
  logic        r_long [LOGN];
  logic        r_err [LOGN];
  logic        r_first [LOGN];
  int          r_ofs [LOGN];
  int          r_cyc [LOGN];
  int bn = 0;
  int b_bytes, b_cyc;
  logic b_noeot;
  int ln = 0;
  int l_null, l_blank, l_pixel, l_sync, l_other;

  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    if (rec_valid && rn < LOGN) begin
      r_dt[rn] = rec_dt; r_vc[rn] = rec_vc; r_par[rn] = rec_param;
      r_long[rn] = rec_long; r_err[rn] = rec_ecc_err; r_first[rn] = rec_first;
      r_ofs[rn] = int'(rec_offset); r_cyc[rn] = cyc; rn = rn + 1;
    end
    if (burst_done) begin
      bn = bn + 1; b_bytes = int'(burst_bytes); b_noeot = burst_no_eot; b_cyc = cyc;
    end
    if (line_valid) begin
      ln = ln + 1; l_null = int'(line_null); l_blank = int'(line_blank);
      l_pixel = int'(line_pixel); l_sync = int'(line_sync); l_other = int'(line_other);
    end
  end

  // header code restated as per-bit column syndromes
  localparam logic [5:0] COL [24] = '{6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
                                      6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
                                      6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B};
  function automatic logic [7:0] ref_ecc(input logic [7:0] id, input logic [7:0] p1, input logic [7:0] p2);
    logic [23:0] d = {p2, p1, id};
    logic [5:0] e = 6'h00;
    for (int i = 0; i < 24; i++) if (d[i]) e = e ^ COL[i];
    return {2'b00, e};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1; byte_data = b; burst_end = 1'b0; last_cyc = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_valid = 1'b0; burst_end = 1'b0;
    end
  endtask

  task automatic end_burst();
    @(negedge clk); byte_valid = 1'b0; burst_end = 1'b1; last_cyc = cyc;
    @(negedge clk); burst_end = 1'b0;
  endtask

  task automatic send_short(input logic [1:0] vc, input logic [5:0] dt, input logic [7:0] p1, input logic [7:0] p2, input logic [7:0] ecc_x);
    logic [7:0] id = {vc, dt};
    send_byte(id); send_byte(p1); send_byte(p2); send_byte(ref_ecc(id, p1, p2) ^ ecc_x);
  endtask

  task automatic send_long(input logic [1:0] vc, input logic [5:0] dt, input int wc, input logic [7:0] ecc_x);
    logic [7:0] id = {vc, dt};
    logic [15:0] w = 16'(wc);
    send_byte(id); send_byte(w[7:0]); send_byte(w[15:8]);
    send_byte(ref_ecc(id, w[7:0], w[15:8]) ^ ecc_x);
    for (int i = 0; i < wc; i++) send_byte(8'(i * 7 + 3));
    send_byte(8'hFF); send_byte(8'hFF);
  endtask

  task automatic t_reset();
    chk("R1 rec_valid at reset", int'(rec_valid), 0);
    chk("R1 burst_done at reset", int'(burst_done), 0);
    chk("R1 line_valid at reset", int'(line_valid), 0);
  endtask

  task automatic t_short();
    int c;
    rn = 0;
    send_short(2'd2, 6'h21, 8'h34, 8'h12, 8'h00);
    c = last_cyc;
    idle(3);
    chk("R2 record count", rn, 1);
    chk("R2 record cycle", r_cyc[0], c + 1);
    chk("R2 vc", int'(r_vc[0]), 2);
    chk("R2 dt", int'(r_dt[0]), 'h21);
    chk("R2 param", int'(r_par[0]), 'h1234);
    chk("R2 short", int'(r_long[0]), 0);
    chk("R4 good ecc", int'(r_err[0]), 0);
    chk("R6 first", int'(r_first[0]), 1);
    chk("R6 offset", r_ofs[0], 0);
    end_burst(); idle(2);
  endtask

  task automatic t_long();
    rn = 0;
    send_long(2'd0, 6'h09, 0, 8'h00);
    send_long(2'd0, 6'h3E, 'h468, 8'h00);
    send_short(2'd0, 6'h01, 8'h00, 8'h00, 8'h00);
    idle(3);
    chk("R3 record count", rn, 3);
    chk("R3 null long", int'(r_long[0]), 1);
    chk("R3 null wc", int'(r_par[0]), 0);
    chk("R3 pixel dt", int'(r_dt[1]), 'h3E);
    chk("R3 pixel wc", int'(r_par[1]), 'h468);
    chk("R6 pixel offset", r_ofs[1], 6);
    chk("R6 pixel not first", int'(r_first[1]), 0);
    chk("R3 vss after payload dt", int'(r_dt[2]), 'h01);
    chk("R6 vss offset", r_ofs[2], 1140);
    chk("R4 pixel ecc", int'(r_err[1]), 0);
    end_burst(); idle(2);
  endtask

  task automatic t_unknown();
    rn = 0;
    send_long(2'd1, 6'h2B, 3, 8'h00);
    send_short(2'd0, 6'h07, 8'hAA, 8'h55, 8'h00);
    idle(3);
    chk("R3 unknown count", rn, 2);
    chk("R3 unknown long", int'(r_long[0]), 1);
    chk("R3 unknown wc", int'(r_par[0]), 3);
    chk("R3 unknown next short", int'(r_long[1]), 0);
    chk("R3 unknown next offset", r_ofs[1], 9);
    end_burst(); idle(2);
  endtask

  task automatic t_ecc();
    rn = 0;
    send_long(2'd0, 6'h09, 2, 8'h01);
    send_short(2'd0, 6'h05, 8'h10, 8'h20, 8'h00);
    send_short(2'd0, 6'h05, 8'h10, 8'h20, 8'hC0);
    idle(3);
    chk("R4 record count", rn, 3);
    chk("R4 flipped bit flagged", int'(r_err[0]), 1);
    chk("R4 length still used", r_ofs[1], 8);
    chk("R4 clean header", int'(r_err[1]), 0);
    chk("R4 top bits flagged", int'(r_err[2]), 1);
    end_burst(); idle(2);
  endtask

  task automatic t_burst();
    int b0, c;
    // burst closed right after an end-of-transmission packet
    b0 = bn;
    send_short(2'd0, 6'h31, 8'h00, 8'h00, 8'h00);
    send_short(2'd0, 6'h08, 8'h00, 8'h00, 8'h00);
    end_burst(); c = last_cyc; idle(2);
    chk("R7 done count A", bn - b0, 1);
    chk("R7 done cycle A", b_cyc, c + 1);
    chk("R7 bytes A", b_bytes, 8);
    chk("R7 eot present A", int'(b_noeot), 0);
    // burst without end-of-transmission
    send_short(2'd0, 6'h31, 8'h00, 8'h00, 8'h00);
    idle(2); end_burst(); idle(2);
    chk("R7 bytes B", b_bytes, 4);
    chk("R7 eot missing B", int'(b_noeot), 1);
    // empty burst gives no summary
    b0 = bn;
    end_burst(); idle(2);
    chk("R7 empty burst", bn - b0, 0);
    // cut in payload, then new burst
    rn = 0;
    send_byte(8'h3E); send_byte(8'd100); send_byte(8'h00); send_byte(ref_ecc(8'h3E, 8'd100, 8'h00));
    for (int i = 0; i < 10; i++) send_byte(8'h11);
    end_burst(); idle(2);
    chk("R7 bytes C", b_bytes, 14);
    chk("R7 eot missing C", int'(b_noeot), 1);
    send_short(2'd0, 6'h11, 8'h00, 8'h00, 8'h00);
    idle(3);
    chk("R5 records after payload cut", rn, 2);
    chk("R5 new burst dt", int'(r_dt[1]), 'h11);
    chk("R5 new burst first", int'(r_first[1]), 1);
    chk("R5 new burst offset", r_ofs[1], 0);
    end_burst(); idle(2);
    // cut inside header, byte offered with burst_end is ignored
    rn = 0;
    send_byte(8'h21); send_byte(8'h00);
    @(negedge clk); byte_valid = 1'b1; byte_data = 8'h00; burst_end = 1'b1;
    @(negedge clk); byte_valid = 1'b0; burst_end = 1'b0;
    idle(2);
    chk("R5 header cut no record", rn, 0);
    chk("R7 bytes D", b_bytes, 2);
    send_short(2'd0, 6'h11, 8'h00, 8'h00, 8'h00);
    idle(3);
    chk("R5 after header cut count", rn, 1);
    chk("R5 after header cut dt", int'(r_dt[0]), 'h11);
    chk("R6 after header cut offset", r_ofs[0], 0);
    end_burst(); idle(2);
  endtask

  task automatic t_lines();
    send_short(2'd0, 6'h21, 8'h00, 8'h00, 8'h00);
    idle(3);
    ln = 0;
    send_long(2'd0, 6'h09, 0, 8'h00);
    send_long(2'd0, 6'h09, 0, 8'h00);
    send_long(2'd2, 6'h19, 4, 8'h00);
    send_long(2'd0, 6'h3E, 6, 8'h00);
    send_short(2'd0, 6'h31, 8'h00, 8'h00, 8'h00);
    send_short(2'd1, 6'h05, 8'h00, 8'h00, 8'h00);
    send_long(2'd3, 6'h09, 0, 8'h00);
    send_short(2'd0, 6'h21, 8'h00, 8'h00, 8'h00);
    idle(3);
    chk("R8 one line report", ln, 1);
    chk("R9 null count", l_null, 3);
    chk("R9 blank count", l_blank, 1);
    chk("R9 pixel count", l_pixel, 1);
    chk("R8 sync count", l_sync, 2);
    chk("R9 other count", l_other, 1);
    end_burst(); idle(2);
  endtask

  task automatic t_sat();
    rn = 0;
    send_short(2'd0, 6'h21, 8'h00, 8'h00, 8'h00);
    for (int i = 0; i < 260; i++) send_short(2'd0, 6'h05, 8'h00, 8'h00, 8'h00);
    ln = 0;
    send_short(2'd0, 6'h21, 8'h00, 8'h00, 8'h00);
    idle(3);
    chk("R10 line report", ln, 1);
    chk("R10 other saturates", l_other, 255);
    chk("R10 sync count", l_sync, 1);
    chk("R10 null count", l_null, 0);
    end_burst(); idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_long();
    t_unknown();
    t_ecc();
    t_burst();
    t_lines();
    t_sat();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule